// File: doc/BRIEF.md
# Self-Checking Approximate Substring Match Array

This block is a one-directional chain of M processing elements that scores a long text stream against a short pattern. Each PE owns one pattern character. For every text character it computes the smallest number of insertions, deletions and substitutions that turn the pattern into some stretch of text ending at that character. Text characters move one PE to the right per clock. The last PE gives one distance per character. The block also keeps the smallest distance seen so far.

The input stream can carry a check token in place of a character. When a PE holds the token, it does not do its own work. It runs its left neighbour's operation on the neighbour's operands in the same cycle and compares its answer with the neighbour's answer. Its own stored state is left alone. The token then moves right, so every adjacent pair gets checked in turn. No spare PE is needed. The user decides at run time how many tokens to insert, trading throughput for checking coverage. A mismatch sets a sticky error flag and records which PE saw it first.

A build-time parameter can force one PE's arithmetic result to a constant. This shows that the checking logic finds such a fault.

Top module: `sda_array`

## Requirements
- R1: For text position i, out_dist is D[i,M]. The recurrence is D[i,j] = min(D[i-1,j]+1, D[i,j-1]+1, D[i-1,j-1] + (text char == pattern char j ? 0 : 1)), with D[i,0]=0. The pattern character of PE j (columns numbered from 0) is pat[j*CW +: CW].
- R2: A character sampled on a rising edge shows on out_vld/out_dist just after the M-th rising edge, counting the sampling edge as the first. Each PE adds exactly one cycle.
- R3: Characters presented on consecutive cycles give valid results on consecutive cycles, one per character, in input order.
- R4: in_tok=1 marks a token, whatever in_vld and in_ch hold. A token gives no out_vld pulse and changes no PE state. The results for the characters are the same as for the same stream with the token removed.
- R5: A PE with index j≥1 checks only when it holds a token and PE j-1 is processing a character in the same cycle. PE 0 passes a token on without checking. A token followed by an idle cycle checks nothing.
- R6: err is sticky. err_pe holds the index of the checking PE (the right-hand PE of the pair) for the first mismatch. Later mismatches do not change it. If several mismatches happen in the same cycle, the lowest index wins.
- R7: clr is synchronous. It clears err and err_pe to 0 and sets best to all ones, and it takes priority over a mismatch in the same cycle. After a clear, the next mismatch is captured again.
- R8: best is the minimum out_dist seen since reset or the last clr. It is updated one cycle after each out_vld.
- R9: After reset: out_vld=0, err=0, err_pe=0 and best is all ones. PE j's stored distance is j+1, which is the empty-text boundary value for its column.
- R10: On a fault-free array, tokens separated by at least one character may be in flight together. Each checks its own pair, err stays 0, and the results are unaffected.
- R11: When parameter FLT_PE selects a PE whose result is forced to FLT_VAL, a token followed by a character for which that PE's left neighbour gives a different value sets err, with err_pe = FLT_PE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the error record and the running minimum |
| in_vld | input | 1 | A text character is present on in_ch |
| in_tok | input | 1 | A check token is present; overrides in_vld |
| in_ch | input | CW | Text character |
| pat | input | M*CW | Pattern, PE j's character at bits j*CW +: CW; held static |
| out_vld | output | 1 | out_dist carries a result |
| out_dist | output | $clog2(M+1) | Minimum distance for substrings ending at the character |
| best | output | $clog2(M+1) | Running minimum of out_dist |
| err | output | 1 | Sticky mismatch flag |
| err_pe | output | max(1,$clog2(M)) | Index of the checking PE of the first mismatch |

## Verification
A wrong stored distance in any PE shows up at out_dist one to M cycles after the next character reaches that PE. It also corrupts every later result that depends on it, so the bench's software model of the recurrence catches it at the first affected output. A fault in one PE's arithmetic stays hidden on the result path when its value happens to be correct. It becomes visible on err a few cycles after a token passes that PE, provided a character follows the token. The bench uses a second, faulted instance and checks both the captured index and its persistence across later mismatches.

// File: rtl/sda_pkg.sv
// Shared definitions for the approximate substring match array.
// Assumes: nothing beyond standard SystemVerilog.
package sda_pkg;

    // What a PE does in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_OWN  = 2'd1,
        OP_TOK  = 2'd2
    } pe_op_e;

    // Width of an index that selects one of n items, never below one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sda_cell_pu.sv
// One edit-distance step: minimum of the up, left and diagonal candidates.
// All increments saturate at the top of the DW-bit range.
// Assumes: operands are stable for the whole cycle (purely combinational).
// STUCK replaces the result by STUCK_VAL to model a faulty unit.
module sda_cell_pu #(
    parameter int CW        = 8,
    parameter int DW        = 3,
    parameter bit STUCK     = 1'b0,
    parameter int STUCK_VAL = 0
) (
    input  logic [CW-1:0] ch,
    input  logic [CW-1:0] pch,
    input  logic [DW-1:0] left,
    input  logic [DW-1:0] up,
    input  logic [DW-1:0] diag,
    output logic [DW-1:0] res
);
    localparam logic [DW-1:0] TOPV = '1;

    logic [DW-1:0] up_i, left_i, diag_i, min_ul, true_res;

    // Candidate costs with saturating increments
    always_comb begin
        up_i   = (up == TOPV)   ? up   : up   + DW'(1);
        left_i = (left == TOPV) ? left : left + DW'(1);
        if (ch == pch)
            diag_i = diag;
        else
            diag_i = (diag == TOPV) ? diag : diag + DW'(1);
    end

    // Three-way minimum
    always_comb begin
        min_ul   = (up_i < left_i) ? up_i : left_i;
        true_res = (diag_i < min_ul) ? diag_i : min_ul;
    end

    assign res = STUCK ? DW'(STUCK_VAL) : true_res;

endmodule

// File: rtl/sda_pe.sv
// One processing element of the array, handling pattern column IDX.
// On a character: computes its cell, stores it, and forwards the character with
// the new value and the previous stored value (the diagonal for the next PE).
// On a token: runs the left neighbour's step on the neighbour's operands through
// its own unit, compares with the neighbour's result, keeps its state, and
// forwards the token.
// Assumes: in_vld and in_tok never both high on the link (the top guarantees it);
// the neighbour ports are tied to zero for IDX 0.
module sda_pe
    import sda_pkg::*;
#(
    parameter int CW      = 8,
    parameter int DW      = 3,
    parameter int IDX     = 0,
    parameter bit FLT     = 1'b0,
    parameter int FLT_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pch,
    input  logic [CW-1:0] npch,
    input  logic          in_vld,
    input  logic          in_tok,
    input  logic [CW-1:0] in_ch,
    input  logic [DW-1:0] in_cur,
    input  logic [DW-1:0] in_dia,
    input  logic          n_vld,
    input  logic          n_tok,
    input  logic [CW-1:0] n_ch,
    input  logic [DW-1:0] n_cur,
    input  logic [DW-1:0] n_dia,
    input  logic [DW-1:0] n_st,
    input  logic [DW-1:0] n_res,
    output logic          out_vld,
    output logic          out_tok,
    output logic [CW-1:0] out_ch,
    output logic [DW-1:0] out_cur,
    output logic [DW-1:0] out_dia,
    output logic [DW-1:0] st_o,
    output logic [DW-1:0] res_o,
    output logic          mism
);
    localparam bit            HAS_LEFT = (IDX > 0);
    localparam logic [DW-1:0] ST_INIT  = DW'(IDX + 1);

    pe_op_e        op;
    logic          chk_en;
    logic [DW-1:0] st_q;
    logic [CW-1:0] a_ch, a_pch;
    logic [DW-1:0] a_left, a_up, a_diag, pu_res;

    // Decide this cycle's operation; a token overrides data
    always_comb begin
        if (in_tok)
            op = OP_TOK;
        else if (in_vld)
            op = OP_OWN;
        else
            op = OP_IDLE;
    end

    assign chk_en = HAS_LEFT && (op == OP_TOK) && n_vld && !n_tok;

    // Operand select: the neighbour's buffers when checking, own buffers otherwise
    always_comb begin
        if (chk_en) begin
            a_ch   = n_ch;
            a_pch  = npch;
            a_left = n_cur;
            a_up   = n_st;
            a_diag = n_dia;
        end else begin
            a_ch   = in_ch;
            a_pch  = pch;
            a_left = in_cur;
            a_up   = st_q;
            a_diag = in_dia;
        end
    end

    sda_cell_pu #(
        .CW(CW), .DW(DW), .STUCK(FLT), .STUCK_VAL(FLT_VAL)
    ) u_pu (
        .ch(a_ch), .pch(a_pch), .left(a_left), .up(a_up), .diag(a_diag),
        .res(pu_res)
    );

    assign mism  = chk_en && (pu_res != n_res);
    assign res_o = pu_res;
    assign st_o  = st_q;

    // Stored column value and forward link registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_INIT;
            out_vld <= 1'b0;
            out_tok <= 1'b0;
            out_ch  <= '0;
            out_cur <= '0;
            out_dia <= '0;
        end else begin
            case (op)
                OP_OWN: begin
                    st_q    <= pu_res;
                    out_vld <= 1'b1;
                    out_tok <= 1'b0;
                    out_ch  <= in_ch;
                    out_cur <= pu_res;
                    out_dia <= st_q;
                end
                OP_TOK: begin
                    out_vld <= 1'b0;
                    out_tok <= 1'b1;
                    out_ch  <= in_ch;
                end
                default: begin
                    out_vld <= 1'b0;
                    out_tok <= 1'b0;
                end
            endcase
        end
    end

    // R4: a token never disturbs the stored column value
    a_r4_tok_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        in_tok |=> $stable(st_q));

    // R4: a token is forwarded as a token, never as data
    a_r4_tok_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        in_tok |=> (out_tok && !out_vld));

    // R3: a character leaves this PE exactly one cycle later
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_tok) |=> out_vld);

endmodule

// File: rtl/sda_err_trap.sv
// Sticky record of the first pair mismatch.
// Bit k of mism comes from PE k (the right-hand PE of pair k-1,k).
// Assumes: clr is synchronous and wins over a mismatch in the same cycle.
module sda_err_trap #(
    parameter int M  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [M-1:0]  mism,
    output logic          err,
    output logic [IW-1:0] err_pe
);
    logic [IW-1:0] first_idx;
    logic          hit;

    // Lowest-index mismatch of this cycle
    always_comb begin
        hit       = |mism;
        first_idx = '0;
        for (int k = M - 1; k >= 0; k--) begin
            if (mism[k])
                first_idx = IW'(k);
        end
    end

    // Capture once, hold until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err    <= 1'b0;
            err_pe <= '0;
        end else if (clr) begin
            err    <= 1'b0;
            err_pe <= '0;
        end else if (!err && hit) begin
            err    <= 1'b1;
            err_pe <= first_idx;
        end
    end

    // R6: once raised and not cleared, the record does not move
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> (err && $stable(err_pe)));

    // R7: a clear empties the record
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err && err_pe == '0));

    // R5: any mismatch without a clear leads to a raised flag
    a_r5_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mism) && !clr) |=> err);

endmodule

// File: rtl/sda_array.sv
// Top of the self-checking approximate substring match array.
// Link 0 is the raw input stream; link j+1 is the register output of PE j.
// PE j's neighbour view is link j-1, the stored value of PE j-1 and its live
// result. Output is link M. A running minimum and the error trap sit at the end.
// Assumes: pat is static while characters flow; the caller spaces tokens by
// at least one character when it wants every token to check a pair.
module sda_array
    import sda_pkg::*;
#(
    parameter int M       = 4,
    parameter int CW      = 8,
    parameter int FLT_PE  = -1,
    parameter int FLT_VAL = 0,
    localparam int DW     = $clog2(M + 1),
    localparam int IW     = idx_width(M)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_vld,
    input  logic            in_tok,
    input  logic [CW-1:0]   in_ch,
    input  logic [M*CW-1:0] pat,
    output logic            out_vld,
    output logic [DW-1:0]   out_dist,
    output logic [DW-1:0]   best,
    output logic            err,
    output logic [IW-1:0]   err_pe
);
    logic          lk_vld [0:M];
    logic          lk_tok [0:M];
    logic [CW-1:0] lk_ch  [0:M];
    logic [DW-1:0] lk_cur [0:M];
    logic [DW-1:0] lk_dia [0:M];
    logic [DW-1:0] st_v   [0:M-1];
    logic [DW-1:0] res_v  [0:M-1];
    logic [M-1:0]  mism;
    logic          unused_tail;

    // Entry link: a token hides any data flag; column 0 boundary values are zero
    assign lk_vld[0] = in_vld & ~in_tok;
    assign lk_tok[0] = in_tok;
    assign lk_ch[0]  = in_ch;
    assign lk_cur[0] = '0;
    assign lk_dia[0] = '0;

    for (genvar j = 0; j < M; j++) begin : g_pe
        logic          nb_vld, nb_tok;
        logic [CW-1:0] nb_ch, nb_pch;
        logic [DW-1:0] nb_cur, nb_dia, nb_st, nb_res;

        if (j == 0) begin : g_edge
            assign nb_vld = 1'b0;
            assign nb_tok = 1'b0;
            assign nb_ch  = '0;
            assign nb_pch = '0;
            assign nb_cur = '0;
            assign nb_dia = '0;
            assign nb_st  = '0;
            assign nb_res = '0;
        end else begin : g_inner
            assign nb_vld = lk_vld[j-1];
            assign nb_tok = lk_tok[j-1];
            assign nb_ch  = lk_ch[j-1];
            assign nb_pch = pat[(j-1)*CW +: CW];
            assign nb_cur = lk_cur[j-1];
            assign nb_dia = lk_dia[j-1];
            assign nb_st  = st_v[j-1];
            assign nb_res = res_v[j-1];
        end

        sda_pe #(
            .CW(CW), .DW(DW), .IDX(j),
            .FLT(FLT_PE == j), .FLT_VAL(FLT_VAL)
        ) u_pe (
            .clk(clk), .rst_n(rst_n),
            .pch(pat[j*CW +: CW]), .npch(nb_pch),
            .in_vld(lk_vld[j]), .in_tok(lk_tok[j]), .in_ch(lk_ch[j]),
            .in_cur(lk_cur[j]), .in_dia(lk_dia[j]),
            .n_vld(nb_vld), .n_tok(nb_tok), .n_ch(nb_ch),
            .n_cur(nb_cur), .n_dia(nb_dia), .n_st(nb_st), .n_res(nb_res),
            .out_vld(lk_vld[j+1]), .out_tok(lk_tok[j+1]), .out_ch(lk_ch[j+1]),
            .out_cur(lk_cur[j+1]), .out_dia(lk_dia[j+1]),
            .st_o(st_v[j]), .res_o(res_v[j]), .mism(mism[j])
        );
    end

    assign out_vld     = lk_vld[M];
    assign out_dist    = lk_cur[M];
    assign unused_tail = ^{lk_ch[M], lk_dia[M], lk_tok[M]};

    // Running minimum of the per-character distance
    always_ff @(posedge clk) begin
        if (!rst_n)
            best <= '1;
        else if (clr)
            best <= '1;
        else if (out_vld && (out_dist < best))
            best <= out_dist;
    end

    sda_err_trap #(.M(M), .IW(IW)) u_trap (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mism(mism),
        .err(err), .err_pe(err_pe)
    );

    // R1: a substring distance never exceeds the pattern length
    a_r1_dist_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_dist <= DW'(M)));

    // R8: without a clear the running minimum never rises
    a_r8_best_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (best <= $past(best)));

    // R7: a clear restarts the running minimum
    a_r7_best_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (best == '1));

endmodule

// File: tb/sim_sda_array.sv
// Scoreboard bench: driver tasks push model results into a queue, a monitor
// pops them on every valid output. u0 is fault-free; u1 has PE 2 stuck at 0.
module sim_sda_array;
    localparam int M  = 4;
    localparam int CW = 8;
    localparam int DW = $clog2(M + 1);
    localparam int IW = (M > 1) ? $clog2(M) : 1;
    localparam int TOPV = (1 << DW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            in_vld = 1'b0;
    logic            in_tok = 1'b0;
    logic [CW-1:0]   in_ch = '0;
    logic [M*CW-1:0] pat = {8'h64, 8'h63, 8'h62, 8'h61};  // PE0..3 = a b c d

    logic            o0_vld, o0_err, o1_vld, o1_err;
    logic [DW-1:0]   o0_dist, o0_best, o1_dist, o1_best;
    logic [IW-1:0]   o0_pe, o1_pe;

    int nchk = 0;
    int nfail = 0;
    int expq[$];
    int mrow[0:M];
    int bmin = TOPV;

    always #2 clk = ~clk;

    sda_array #(.M(M), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_tok(in_tok),
        .in_ch(in_ch), .pat(pat), .out_vld(o0_vld), .out_dist(o0_dist),
        .best(o0_best), .err(o0_err), .err_pe(o0_pe)
    );

    sda_array #(.M(M), .CW(CW), .FLT_PE(2), .FLT_VAL(0)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_tok(in_tok),
        .in_ch(in_ch), .pat(pat), .out_vld(o1_vld), .out_dist(o1_dist),
        .best(o1_best), .err(o1_err), .err_pe(o1_pe)
    );

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Software model of one text step; returns D[i,M]
    task automatic model_step(input logic [CW-1:0] c, output int dm);
        int nr[0:M];
        nr[0] = 0;
        for (int j = 1; j <= M; j++) begin
            int d, u, l, m;
            d = mrow[j-1] + ((c == pat[(j-1)*CW +: CW]) ? 0 : 1);
            u = mrow[j] + 1;
            l = nr[j-1] + 1;
            m = (u < l) ? u : l;
            nr[j] = (d < m) ? d : m;
        end
        for (int j = 0; j <= M; j++) mrow[j] = nr[j];
        dm = nr[M];
    endtask

    task automatic put_ch(input logic [CW-1:0] c);
        int dm;
        model_step(c, dm);
        expq.push_back(dm);
        in_vld = 1'b1; in_tok = 1'b0; in_ch = c;
        @(negedge clk);
    endtask

    // Token with in_vld also high: the token must win (R4)
    task automatic put_tok();
        in_vld = 1'b1; in_tok = 1'b1; in_ch = 8'h61;
        @(negedge clk);
    endtask

    task automatic put_idle(input int n);
        in_vld = 1'b0; in_tok = 1'b0; in_ch = '0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every valid output is checked against the model (R1, R4)
    always @(negedge clk) begin
        if (rst_n && o0_vld) begin
            if (expq.size() == 0) begin
                chk("R4 unexpected output", 1, 0);
            end else begin
                int e;
                e = expq.pop_front();
                chk("R1 distance", int'(o0_dist), e);
                if (e < bmin) bmin = e;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int j = 0; j <= M; j++) mrow[j] = j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 out_vld", int'(o0_vld), 0);
        chk("R9 err", int'(o0_err), 0);
        chk("R9 err_pe", int'(o0_pe), 0);
        chk("R9 best", int'(o0_best), TOPV);

        // R2 latency and R9 boundary: first char 'a' gives 3
        fork
            begin put_ch(8'h61); put_idle(M + 2); end
            begin
                repeat (M - 1) @(posedge clk);
                @(negedge clk);
                chk("R2 not yet valid", int'(o0_vld), 0);
                @(negedge clk);
                chk("R2 valid at M edges", int'(o0_vld), 1);
                chk("R9 first result from boundary", int'(o0_dist), 3);
            end
        join

        // R3: back-to-back burst gives back-to-back results
        fork
            begin
                put_ch(8'h78); put_ch(8'h61); put_ch(8'h62);
                put_ch(8'h63); put_ch(8'h64); put_ch(8'h7a);
                put_idle(M + 2);
            end
            begin
                repeat (M) @(posedge clk);
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    chk("R3 consecutive valid", int'(o0_vld), 1);
                end
                @(negedge clk);
                chk("R3 burst ends", int'(o0_vld), 0);
            end
        join

        // R5: token followed by an idle cycle checks nothing, even on u1
        put_tok(); put_idle(1); put_ch(8'h63); put_ch(8'h64); put_idle(M + 2);
        chk("R5 no check without neighbour data", int'(o1_err), 0);
        chk("R5 clean array", int'(o0_err), 0);

        // R11: token then 'x' exposes the stuck PE 2
        put_tok(); put_ch(8'h78); put_ch(8'h61); put_idle(M + 2);
        chk("R11 fault flagged", int'(o1_err), 1);
        chk("R11 fault index", int'(o1_pe), 2);
        chk("R10 clean array no flag", int'(o0_err), 0);

        // R6: a later mismatch at PE 3 leaves the record at 2
        put_ch(8'h61); put_tok(); put_ch(8'h62); put_idle(M + 2);
        chk("R6 sticky flag", int'(o1_err), 1);
        chk("R6 first index kept", int'(o1_pe), 2);

        // R7: clear, then the same pattern is captured afresh at PE 3
        clr = 1'b1; bmin = TOPV;
        @(negedge clk);
        clr = 1'b0;
        chk("R7 err cleared", int'(o1_err), 0);
        chk("R7 index cleared", int'(o1_pe), 0);
        chk("R7 best restarted", int'(o0_best), TOPV);
        put_ch(8'h61); put_tok(); put_ch(8'h62); put_idle(M + 2);
        chk("R7 recapture flag", int'(o1_err), 1);
        chk("R7 recapture index", int'(o1_pe), 3);

        // R10/R4: several tokens in flight on the clean array
        put_tok(); put_ch(8'h63); put_tok(); put_ch(8'h61);
        put_tok(); put_ch(8'h62); put_tok(); put_ch(8'h64);
        put_ch(8'h78); put_idle(M + 3);
        chk("R10 no false flag", int'(o0_err), 0);
        chk("R4 all results delivered", expq.size(), 0);

        // R8: running minimum since the clear
        chk("R8 best", int'(o0_best), bmin);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule